// File: doc/BRIEF.md
# Programmable Burst Write Sequencer

This block takes one 256-bit line write request at a time and plays it out to a narrow memory-side write port as four consecutive 64-bit beats. The first beat is the leadoff. It carries the line's base address and lasts a programmable number of cycles. Each of the three following beats goes to the next 8-byte location and lasts an equal, separately programmed number of cycles. This gives the familiar x-y-y-y write profile.

The timing comes from a small register set that is loaded with a single-cycle load strobe. In automatic mode, fixed built-in timing is used and writes to the timing fields have no effect. Switching into manual mode puts the write beat setting at its slowest value. The beat length may be written as a total cycle count or as a wait-state count (one less than the total). A share bit makes the read beat field govern writes as well. The timing is captured when a request is accepted, so a burst already under way keeps the values it started with.

Top module: `burst_write_seq`

## Requirements
- R1: A burst emits exactly four write strobes. Beat k (k = 0..3) drives data bits [64k+63:64k] of the request line.
- R2: The beat address is the request address with its low five bits cleared, plus 8·k for beat k. `mem_first` is high exactly during the first beat.
- R3: `mem_we` is high for exactly one cycle, on the last cycle of each beat. With the request accepted at edge E, the strobe of beat 0 falls x cycles after E. Each later strobe follows the one before it by y cycles.
- R4: In total-count format (`cfg_wait_fmt`=0), y is the beat field. In wait-state format (`cfg_wait_fmt`=1), y is the field plus one. The result is clamped to the range 1..4, so a total-count field of 0 gives 1 and a value above 4 gives 4.
- R5: In manual mode the leadoff x is the leadoff field, raised to y+1 when the field is not larger than y.
- R6: While the stored mode is automatic (`cfg_auto`=1 at load, the reset value), x=5 and y=2. In that mode a load leaves the stored leadoff and beat fields unchanged.
- R7: A load that changes the mode from automatic to manual sets the write beat field to its slowest setting (y=4), whatever value was written. Later manual loads take the written value.
- R8: With `cfg_share`=1 the read beat field sets y in place of the write beat field.
- R9: `req_ready` is high only when idle. It stays low from acceptance through the `done` cycle. `done` is a one-cycle pulse in the cycle after the fourth strobe. `req_valid` has no effect while busy.
- R10: A load during a burst has no effect on that burst's timing. It applies from the next accepted request onward.
- R11: After reset, `req_ready`=1, `done`=0 and `mem_we`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Writes the configuration inputs into the timing registers |
| cfg_auto | input | 1 | 1 selects automatic timing |
| cfg_wait_fmt | input | 1 | 1: beat fields are wait-state counts |
| cfg_share | input | 1 | 1: read beat field also times writes |
| cfg_lead | input | 4 | Leadoff cycle count |
| cfg_wr_beat | input | 4 | Write beat length field |
| cfg_rd_beat | input | 4 | Read beat length field |
| req_valid | input | 1 | Line write request |
| req_ready | output | 1 | Idle, request will be accepted |
| req_addr | input | 32 | Line byte address |
| req_data | input | 256 | Line data |
| done | output | 1 | One-cycle end-of-burst pulse |
| mem_we | output | 1 | Beat write strobe |
| mem_first | output | 1 | High during the leadoff beat |
| mem_addr | output | 32 | Current beat byte address |
| mem_data | output | 64 | Current beat data |

## Verification
A bad beat index shows up at the next strobe as the wrong data slice or a wrong address step. A bad cycle counter moves the strobe away from its x or y slot, and this is visible at that beat's edge. A stale or misdecoded configuration register shows up from the first strobe of the next burst as the wrong leadoff delay. A state machine that leaves busy too early or too late shows up as `done` arriving in the wrong cycle, or as a fifth strobe.

// File: rtl/bws_pkg.sv
// Shared types for the burst write sequencer.
package bws_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_BEAT,
        ST_DONE
    } bws_state_t;
endpackage

// File: rtl/bws_cfg_regs.sv
// Timing configuration registers and decode.
// Holds the mode, format, share and field values. It turns them into an
// effective leadoff length and beat length, both in cycles.
// Assumes AUTO_LEAD > AUTO_BEAT and 1 <= AUTO_BEAT <= MAX_BEAT.
module bws_cfg_regs #(
    parameter int CNT_W     = 4,
    parameter int MAX_BEAT  = 4,
    parameter int AUTO_LEAD = 5,
    parameter int AUTO_BEAT = 2,
    localparam int TW       = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic             cfg_auto,
    input  logic             cfg_wait_fmt,
    input  logic             cfg_share,
    input  logic [CNT_W-1:0] cfg_lead,
    input  logic [CNT_W-1:0] cfg_wr_beat,
    input  logic [CNT_W-1:0] cfg_rd_beat,
    output logic [TW-1:0]    lead_cyc,
    output logic [TW-1:0]    beat_cyc
);
    localparam logic [CNT_W-1:0] SLOW_TOTAL = CNT_W'(MAX_BEAT);
    localparam logic [CNT_W-1:0] SLOW_WAIT  = CNT_W'(MAX_BEAT - 1);
    localparam logic [TW-1:0]    MAX_Y      = TW'(MAX_BEAT);

    logic             auto_q, fmt_q, share_q;
    logic [CNT_W-1:0] lead_q, wbeat_q, rbeat_q;
    logic [TW-1:0]    raw_y, man_y, man_x;
    logic [CNT_W-1:0] beat_src;

    // Register load: timing fields are locked in automatic mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auto_q  <= 1'b1;
            fmt_q   <= 1'b0;
            share_q <= 1'b0;
            lead_q  <= CNT_W'(AUTO_LEAD);
            wbeat_q <= SLOW_TOTAL;
            rbeat_q <= SLOW_TOTAL;
        end else if (cfg_load) begin
            auto_q  <= cfg_auto;
            fmt_q   <= cfg_wait_fmt;
            share_q <= cfg_share;
            if (!cfg_auto) begin
                lead_q  <= cfg_lead;
                rbeat_q <= cfg_rd_beat;
                if (auto_q) begin
                    wbeat_q <= cfg_wait_fmt ? SLOW_WAIT : SLOW_TOTAL;
                end else begin
                    wbeat_q <= cfg_wr_beat;
                end
            end
        end
    end

    // Decode the stored fields into effective cycle counts.
    always_comb begin
        beat_src = share_q ? rbeat_q : wbeat_q;
        raw_y    = {1'b0, beat_src} + TW'(fmt_q);
        if (raw_y == '0) begin
            man_y = TW'(1);
        end else if (raw_y > MAX_Y) begin
            man_y = MAX_Y;
        end else begin
            man_y = raw_y;
        end
        if ({1'b0, lead_q} > man_y) begin
            man_x = {1'b0, lead_q};
        end else begin
            man_x = man_y + TW'(1);
        end
        lead_cyc = auto_q ? TW'(AUTO_LEAD) : man_x;
        beat_cyc = auto_q ? TW'(AUTO_BEAT) : man_y;
    end
endmodule

// File: rtl/bws_beat_ctrl.sv
// Burst sequencing state machine.
// Accepts a request when idle and latches the effective timing. It counts
// the leadoff beat and then the remaining beats, strobes on the last cycle
// of each beat, and ends with a one-cycle done state.
// Assumes lead_cyc and beat_cyc are at least 1.
module bws_beat_ctrl
    import bws_pkg::*;
#(
    parameter int BEATS = 4,
    parameter int TW    = 5,
    localparam int IDX_W = $clog2(BEATS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [TW-1:0]    lead_cyc,
    input  logic [TW-1:0]    beat_cyc,
    output logic             accept,
    output logic             req_ready,
    output logic             done,
    output logic             strobe,
    output logic             first,
    output logic [IDX_W-1:0] beat_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);

    bws_state_t    state_q;
    logic [TW-1:0] cnt_q, lead_q, beat_q, limit;

    // Output and end-of-beat decode.
    always_comb begin
        limit     = (state_q == ST_LEAD) ? lead_q : beat_q;
        req_ready = (state_q == ST_IDLE);
        accept    = req_ready && req_valid;
        done      = (state_q == ST_DONE);
        first     = (state_q == ST_LEAD);
        strobe    = ((state_q == ST_LEAD) || (state_q == ST_BEAT)) && (cnt_q == limit);
    end

    // State, beat index and cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            lead_q   <= '0;
            beat_q   <= '0;
            beat_idx <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        state_q  <= ST_LEAD;
                        cnt_q    <= TW'(1);
                        lead_q   <= lead_cyc;
                        beat_q   <= beat_cyc;
                        beat_idx <= '0;
                    end
                end
                ST_LEAD, ST_BEAT: begin
                    if (strobe) begin
                        if (beat_idx == LAST_IDX) begin
                            state_q <= ST_DONE;
                        end else begin
                            state_q  <= ST_BEAT;
                            beat_idx <= beat_idx + IDX_W'(1);
                            cnt_q    <= TW'(1);
                        end
                    end else begin
                        cnt_q <= cnt_q + TW'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bws_datapath.sv
// Line capture and beat selection.
// Latches the aligned base address and the line at acceptance. It forms
// each beat address by inserting the beat index above the byte offset and
// picks the matching data slice.
// Assumes BEAT_W/8 and BEATS are powers of two.
module bws_datapath #(
    parameter int ADDR_W = 32,
    parameter int BEAT_W = 64,
    parameter int BEATS  = 4,
    localparam int IDX_W  = $clog2(BEATS),
    localparam int BYTE_W = $clog2(BEAT_W / 8),
    localparam int OFF_W  = IDX_W + BYTE_W,
    localparam int LINE_W = BEAT_W * BEATS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LINE_W-1:0] req_data,
    input  logic [IDX_W-1:0]  beat_idx,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BEAT_W-1:0] mem_data
);
    localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((1 << OFF_W) - 1);

    logic [ADDR_W-1:0] base_q;
    logic [LINE_W-1:0] line_q;
    logic [BEAT_W-1:0] slices [BEATS];

    // Capture the aligned base and the line on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            line_q <= '0;
        end else if (accept) begin
            base_q <= req_addr & ~OFF_MASK;
            line_q <= req_data;
        end
    end

    for (genvar g = 0; g < BEATS; g++) begin : g_slice
        assign slices[g] = line_q[g*BEAT_W +: BEAT_W];
    end

    // Beat address and data selection.
    always_comb begin
        mem_addr = base_q | ADDR_W'({beat_idx, {BYTE_W{1'b0}}});
        mem_data = slices[beat_idx];
    end
endmodule

// File: rtl/burst_write_seq.sv
// Top level of the burst write sequencer.
// Connects the configuration decode, the beat controller and the line
// datapath. It assumes a request is held with valid data until req_ready
// is seen high at a clock edge.
module burst_write_seq #(
    parameter int ADDR_W    = 32,
    parameter int BEAT_W    = 64,
    parameter int BEATS     = 4,
    parameter int CNT_W     = 4,
    parameter int MAX_BEAT  = 4,
    parameter int AUTO_LEAD = 5,
    parameter int AUTO_BEAT = 2,
    localparam int LINE_W   = BEAT_W * BEATS,
    localparam int TW       = CNT_W + 1,
    localparam int IDX_W    = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic              cfg_auto,
    input  logic              cfg_wait_fmt,
    input  logic              cfg_share,
    input  logic [CNT_W-1:0]  cfg_lead,
    input  logic [CNT_W-1:0]  cfg_wr_beat,
    input  logic [CNT_W-1:0]  cfg_rd_beat,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LINE_W-1:0] req_data,
    output logic              done,
    output logic              mem_we,
    output logic              mem_first,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BEAT_W-1:0] mem_data
);
    logic [TW-1:0]    lead_cyc, beat_cyc;
    logic             accept;
    logic [IDX_W-1:0] beat_idx;

    bws_cfg_regs #(
        .CNT_W(CNT_W), .MAX_BEAT(MAX_BEAT),
        .AUTO_LEAD(AUTO_LEAD), .AUTO_BEAT(AUTO_BEAT)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_auto(cfg_auto),
        .cfg_wait_fmt(cfg_wait_fmt), .cfg_share(cfg_share), .cfg_lead(cfg_lead),
        .cfg_wr_beat(cfg_wr_beat), .cfg_rd_beat(cfg_rd_beat),
        .lead_cyc(lead_cyc), .beat_cyc(beat_cyc)
    );

    bws_beat_ctrl #(.BEATS(BEATS), .TW(TW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .lead_cyc(lead_cyc), .beat_cyc(beat_cyc), .accept(accept),
        .req_ready(req_ready), .done(done), .strobe(mem_we),
        .first(mem_first), .beat_idx(beat_idx)
    );

    bws_datapath #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .BEATS(BEATS)) u_dp (
        .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
        .req_data(req_data), .beat_idx(beat_idx),
        .mem_addr(mem_addr), .mem_data(mem_data)
    );
endmodule

// File: rtl/bws_checker.sv
// Protocol checker for the burst write sequencer, bound to the top level.
// Counts strobes per burst and tracks the previous beat address.
module bws_checker #(
    parameter int ADDR_W = 32,
    parameter int BEAT_W = 64,
    parameter int BEATS  = 4,
    localparam int NW    = $clog2(BEATS + 1) + 1,
    localparam int OFF_W = $clog2(BEATS * BEAT_W / 8)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              done,
    input logic              mem_we,
    input logic              mem_first,
    input logic [ADDR_W-1:0] mem_addr
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BEAT_W / 8);

    logic [NW-1:0]     n_we;
    logic [ADDR_W-1:0] last_addr;

    // Strobe count since acceptance and address of the last strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_we      <= '0;
            last_addr <= '0;
        end else begin
            if (req_valid && req_ready) begin
                n_we <= '0;
            end else if (mem_we) begin
                n_we <= n_we + NW'(1);
            end
            if (mem_we) begin
                last_addr <= mem_addr;
            end
        end
    end

    AST_FOUR_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (n_we == NW'(BEATS))); // R1
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_first) |-> (mem_addr == last_addr + STEP)); // R2
    AST_LEAD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_first |-> (mem_addr[OFF_W-1:0] == '0)); // R2
    AST_LEAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_first |-> !req_ready); // R2
    AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_we)); // R3
    AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !req_ready); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready); // R9
endmodule

bind burst_write_seq bws_checker #(
    .ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .BEATS(BEATS)
) u_bws_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .done(done), .mem_we(mem_we), .mem_first(mem_first), .mem_addr(mem_addr)
);

// File: tb/burst_write_seq_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes the expected beats, the monitor checks them.
module burst_write_seq_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_load = 1'b0, cfg_auto = 1'b1, cfg_wait_fmt = 1'b0, cfg_share = 1'b0;
    logic [3:0]   cfg_lead = '0, cfg_wr_beat = '0, cfg_rd_beat = '0;
    logic         req_valid = 1'b0;
    logic         req_ready, done, mem_we, mem_first;
    logic [31:0]  req_addr = '0, mem_addr;
    logic [255:0] req_data = '0;
    logic [63:0]  mem_data;

    burst_write_seq u_burst_write_seq (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_auto(cfg_auto),
        .cfg_wait_fmt(cfg_wait_fmt), .cfg_share(cfg_share), .cfg_lead(cfg_lead),
        .cfg_wr_beat(cfg_wr_beat), .cfg_rd_beat(cfg_rd_beat),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_data(req_data), .done(done), .mem_we(mem_we), .mem_first(mem_first),
        .mem_addr(mem_addr), .mem_data(mem_data)
    );

    always #4 clk = ~clk;

    typedef struct {
        int          t;
        logic [31:0] a;
        logic [63:0] d;
        bit          f;
    } beat_t;

    beat_t exp_q[$];
    int    done_q[$];
    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    bit    finished = 0;

    // Timing model, written from the requirements.
    bit m_auto = 1, m_fmt = 0, m_share = 0;
    int m_lead = 5, m_wb = 4, m_rb = 4;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic void calc(output int x, output int y);
        int src, d;
        if (m_auto) begin
            x = 5; y = 2;
        end else begin
            src = m_share ? m_rb : m_wb;
            d = src + (m_fmt ? 1 : 0);
            y = (d < 1) ? 1 : ((d > 4) ? 4 : d);
            x = (m_lead > y) ? m_lead : y + 1;
        end
    endfunction

    task automatic cfg(input bit au, input bit fm, input bit sh,
                       input int ld, input int wb, input int rb);
        @(negedge clk);
        cfg_auto = au; cfg_wait_fmt = fm; cfg_share = sh;
        cfg_lead = 4'(ld); cfg_wr_beat = 4'(wb); cfg_rd_beat = 4'(rb);
        cfg_load = 1'b1;
        if (!au) begin
            m_lead = ld; m_rb = rb;
            m_wb = m_auto ? (fm ? 3 : 4) : wb;
        end
        m_auto = au; m_fmt = fm; m_share = sh;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic wait_drain();
        @(negedge clk);
        while (exp_q.size() != 0 || done_q.size() != 0 || !req_ready) @(negedge clk);
    endtask

    // Driver: issue one line and push its expected beats.
    task automatic burst(input logic [31:0] a, input logic [255:0] l);
        int x, y, n;
        beat_t b;
        wait_drain();
        calc(x, y);
        n = cyc;
        req_valid = 1'b1; req_addr = a; req_data = l;
        for (int k = 0; k < 4; k++) begin
            b.t = n + x + k * y;
            b.a = {a[31:5], 5'b0} + 32'(8 * k);
            b.d = l[64*k +: 64];
            b.f = (k == 0);
            exp_q.push_back(b);
        end
        done_q.push_back(n + x + 3 * y + 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [255:0] rnd_line();
        logic [255:0] l;
        for (int i = 0; i < 8; i++) l[32*i +: 32] = $urandom;
        return l;
    endfunction

    // Monitor: pop and compare as the design produces beats.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (mem_we) begin
                if (exp_q.size() == 0) begin
                    check(0, "R1", "unexpected strobe", cyc, 0);
                end else begin
                    beat_t b;
                    b = exp_q.pop_front();
                    check(cyc == b.t, "R3", "strobe cycle", cyc, b.t);
                    check(mem_addr == b.a, "R2", "beat address", mem_addr, b.a);
                    check(mem_data == b.d, "R1", "beat data", mem_data, b.d);
                    check(mem_first == b.f, "R2", "first flag", mem_first, b.f);
                    check(!req_ready, "R9", "ready during strobe", req_ready, 0);
                end
            end
            if (exp_q.size() != 0 && exp_q[0].t < cyc) begin
                check(0, "R3", "missed strobe", cyc, exp_q[0].t);
                void'(exp_q.pop_front());
            end
            if (done) begin
                if (done_q.size() == 0) begin
                    check(0, "R9", "unexpected done", cyc, 0);
                end else begin
                    int t;
                    t = done_q.pop_front();
                    check(cyc == t, "R9", "done cycle", cyc, t);
                    check(!req_ready, "R9", "ready during done", req_ready, 0);
                end
            end
            if (done_q.size() != 0 && done_q[0] < cyc) begin
                check(0, "R9", "missed done", cyc, done_q[0]);
                void'(done_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "R9", "watchdog", cyc, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        check(req_ready == 1'b1, "R11", "ready in reset", req_ready, 1);
        check(done == 1'b0, "R11", "done in reset", done, 0);
        check(mem_we == 1'b0, "R11", "strobe in reset", mem_we, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && !mem_we, "R11", "idle after reset", req_ready, 1);

        // R6: automatic defaults, unaligned address (R2)
        burst(32'h1234_567F, rnd_line());
        // R6: timing fields ignored in automatic mode
        cfg(1, 0, 0, 9, 1, 1);
        burst(32'h0000_1020, rnd_line());
        // R7: entering manual mode forces the slowest write beat; R5 raises leadoff
        cfg(0, 0, 0, 3, 1, 2);
        burst(32'hABCD_0008, rnd_line());
        // R9: requests held during a burst are ignored
        burst(32'h0000_4000, rnd_line());
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'hDEAD_0000; req_data = rnd_line();
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        // R7: a later manual load takes the written value; R3 minimum beat
        cfg(0, 0, 0, 6, 1, 2);
        burst(32'h8000_0040, rnd_line());
        // R4: wait-state format, R5 leadoff raised to y+1
        cfg(0, 1, 0, 2, 2, 0);
        burst(32'h0F0F_0F1F, rnd_line());
        // R4: clamp of a large wait-state count
        cfg(0, 1, 0, 7, 7, 0);
        burst(32'h0000_0060, rnd_line());
        // R4: total-count field of zero
        cfg(0, 0, 0, 2, 0, 0);
        burst(32'hFFFF_FFE0, rnd_line());
        // R8: shared read timing
        cfg(0, 0, 1, 3, 1, 3);
        burst(32'h5555_5540, rnd_line());
        // R10: change timing during a burst
        burst(32'h2222_2200, rnd_line());
        cfg(0, 0, 0, 9, 1, 1);
        burst(32'h3333_3300, rnd_line());
        wait_drain();
        check(exp_q.size() == 0, "R1", "beats left over", exp_q.size(), 0);
        finish_run();
    end
endmodule